// File: doc/BRIEF.md
# Dual-Mode Character Store with Sequential Entry

This block keeps a small character memory, eight six-bit cells by default, that a display scanner reads at any time through a separate combinational read port. A host writes into it over a simple strobe bus. The effective strobe is the write strobe, active low, combined with two chip selects. The cell that receives the data comes from one of two sources, chosen on every write:

- **Random mode.** The host names the cell with a three-bit location.
- **Sequential mode.** An internal counter picks the cell. The counter fills the cells from left (cell 0) to right and then reports that it is full.

The full flag and the serial-enable input let several of these blocks be chained. A write stops at a device once it is full. Writes are enabled only while the previous device reports full.

Control information is taken when the strobe asserts: the mode, the location and the serial enable. The data word is taken when the strobe deasserts. This split lets one bus carry the location first and the data second. The strobe and the mode are brought into the system clock with two-flop synchronizers. In sequential mode only, an active-low clear input blanks every cell at once and rewinds the counter. A write-active output tells the scanner to release the memory and blank its drivers while an accepted write is in progress. A shutdown input hides the full flag.

Top module: `dispmem_writer`

## Requirements
- R1: A write is seen only while `wr_n` is 0, `cs_hi` is 1 and `cs_lo_n` is 0. The strobe asserts on whichever of these three inputs completes the condition last, and deasserts on whichever breaks it first. Pulsing `wr_n` while a select is inactive changes nothing.
- R2: `mode_sel` is taken at the asserting edge of the strobe: 1 selects sequential mode and 0 selects random mode. The chosen mode stays in force until the next asserting edge.
- R3: In random mode, `loc_in` is taken at the asserting edge. Changes on `loc_in` after that edge do not affect the write.
- R4: The `wdata` value present at the deasserting edge is stored in the selected cell. `scan_data` always shows the cell named by `scan_addr`. Changes on `wdata` while the strobe is held do not matter.
- R5: In sequential mode, `ser_en` is taken at the asserting edge. The write is accepted only if that enable is 1 and the counter is not full. A refused write changes no cell and no counter state, and `write_active` stays 0.
- R6: The sequential counter starts at cell 0 and advances by one at the deasserting edge of each accepted sequential write. The n-th accepted entry lands in cell n-1.
- R7: `full_flag` is 1 only when all three hold: the mode is sequential, eight accepted sequential entries have been made since the last clear or reset, and `shutdown` is 0. It is 0 in random mode.
- R8: While the mode is sequential, `clr_n` = 0 acts without waiting for a clock edge. Every cell then reads 6'b100000 (blank), the counter returns to 0 and `full_flag` drops. In random mode `clr_n` has no effect.
- R9: For an accepted write, `write_active` rises three clock edges after the strobe-asserting input change. It falls together with the memory update, three edges after the deasserting change.
- R10: After reset, every cell reads blank, the mode is random, and `full_flag` and `write_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| mode_sel | input | 1 | Entry mode: 1 sequential, 0 random |
| loc_in | input | 3 | Target cell in random mode |
| ser_en | input | 1 | Chain enable in sequential mode |
| clr_n | input | 1 | Asynchronous clear in sequential mode, active low |
| wdata | input | 6 | Character code to store |
| shutdown | input | 1 | Forces `full_flag` low |
| scan_addr | input | 3 | Scanner read address |
| scan_data | output | 6 | Cell contents at `scan_addr` |
| full_flag | output | 1 | Sequential counter has filled all cells |
| write_active | output | 1 | Accepted write in progress |

## Verification
The bench targets the following corner cases:

- **Location and data changed while the strobe is held low.** A design that samples the location late writes the wrong cell. A design that samples the data early stores the stale word.
- **Strobe formed by each of the three inputs in turn, and blocked by an inactive select.** A design that watches `wr_n` alone misses the select-driven edges or writes when it should not.
- **A ninth sequential write, and a write with the enable low.** Both must be refused. A design with a wrapping counter or an ungated accept overwrites cell 0.
- **Clear applied in both modes.** A design that ignores the mode wipes the memory during random use.
- **Shutdown and random mode checked while the counter is full.** A design that does not gate the flag shows a stale full indication.

// File: rtl/dmw_pkg.sv
package dmw_pkg;

   typedef enum logic {
      ACC_RANDOM = 1'b0,
      ACC_SEQ    = 1'b1
   } acc_mode_e;

   localparam int unsigned CODE_W_DEF = 6;

   function automatic logic [CODE_W_DEF-1:0] blank_code();
      return {1'b1, {(CODE_W_DEF-1){1'b0}}};
   endfunction

endpackage

// File: rtl/dmw_sync.sv
module dmw_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dmw_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dmw_rst_sync.sv
module dmw_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_out_n
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dmw_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sh <= '0;
      else         sh <= {sh[STAGES-2:0], 1'b1};
   end

   assign rst_out_n = sh[STAGES-1];

endmodule

// File: rtl/dmw_strobe_ctrl.sv
module dmw_strobe_ctrl
   import dmw_pkg::*;
#(
   parameter int unsigned AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb_s,
   input  logic          mode_s,
   input  logic [AW-1:0] loc_i,
   input  logic          sen_i,
   input  logic          full_i,
   output acc_mode_e     mode_q,
   output logic [AW-1:0] loc_q,
   output logic          act_q,
   output logic          commit_o
);

   logic stb_d;
   logic asrt, dsrt;
   logic accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_d <= 1'b0;
      else        stb_d <= stb_s;
   end

   assign asrt = stb_s & ~stb_d;
   assign dsrt = ~stb_s & stb_d;

   always_comb begin
      if (acc_mode_e'(mode_s) == ACC_SEQ) accept = sen_i & ~full_i;
      else                                accept = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= ACC_RANDOM;
         loc_q  <= '0;
         act_q  <= 1'b0;
      end else if (asrt) begin
         mode_q <= acc_mode_e'(mode_s);
         if (acc_mode_e'(mode_s) == ACC_RANDOM) loc_q <= loc_i;
         act_q  <= accept;
      end else if (dsrt) begin
         act_q  <= 1'b0;
      end
   end

   assign commit_o = dsrt & act_q;

   // R9: write_active only rises from a detected asserting edge
   p_act_span_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> $past(asrt));

   // R9: write_active only ends on a detected deasserting edge
   p_act_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_q) |-> $past(dsrt));

endmodule

// File: rtl/dmw_seq_ctr.sv
module dmw_seq_ctr #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] cnt,
   output logic          full
);

   assign full = (cnt == CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (inc && !full) cnt <= cnt + CW'(1);
   end

   // R6: the counter never passes the cell count
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   // R6: outside a clear the counter only steps up by one
   p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/dmw_store.sv
module dmw_store #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned DW    = 6,
   parameter int unsigned AW    = $clog2(DEPTH),
   parameter logic [DW-1:0] BLANK = {1'b1, {(DW-1){1'b0}}}
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DEPTH-1:0][DW-1:0] mem;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           mem[i] <= BLANK;
         else if (we && waddr == AW'(i))       mem[i] <= wdata;
      end
   end

   assign rdata = mem[raddr];

   // R4: no cell moves without a write strobe from the control
   p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mem));

endmodule

// File: rtl/dispmem_writer.sv
module dispmem_writer
   import dmw_pkg::*;
#(
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned DW          = 6,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW         = $clog2(DEPTH),
   localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_n,
   input  logic          cs_hi,
   input  logic          cs_lo_n,
   input  logic          mode_sel,
   input  logic [AW-1:0] loc_in,
   input  logic          ser_en,
   input  logic          clr_n,
   input  logic [DW-1:0] wdata,
   input  logic          shutdown,
   input  logic [AW-1:0] scan_addr,
   output logic [DW-1:0] scan_data,
   output logic          full_flag,
   output logic          write_active
);

   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("dispmem_writer: DEPTH must be a power of two");
   end
   if (DW < 2) begin : g_bad_dw
      $error("dispmem_writer: DW must be at least 2");
   end

   localparam logic [DW-1:0] BLANK = {1'b1, {(DW-1){1'b0}}};

   logic          stb_raw;
   logic [1:0]    sync_q;
   acc_mode_e     mode_q;
   logic [AW-1:0] loc_q;
   logic          act_q, commit;
   logic          clr_arst_n, mem_rst_n;
   logic [CW-1:0] cnt;
   logic          full;
   logic [AW-1:0] waddr;
   logic          seq_inc;

   assign stb_raw = ~wr_n & cs_hi & ~cs_lo_n;

   dmw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({mode_sel, stb_raw}),
      .q    (sync_q)
   );

   dmw_strobe_ctrl #(.AW(AW)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb_s   (sync_q[0]),
      .mode_s  (sync_q[1]),
      .loc_i   (loc_in),
      .sen_i   (ser_en),
      .full_i  (full),
      .mode_q  (mode_q),
      .loc_q   (loc_q),
      .act_q   (act_q),
      .commit_o(commit)
   );

   assign clr_arst_n = rst_n & (clr_n | (mode_q != ACC_SEQ));

   dmw_rst_sync #(.STAGES(SYNC_STAGES)) u_clr (
      .clk      (clk),
      .arst_n   (clr_arst_n),
      .rst_out_n(mem_rst_n)
   );

   assign seq_inc = commit & (mode_q == ACC_SEQ);

   dmw_seq_ctr #(.DEPTH(DEPTH), .CW(CW)) u_ctr (
      .clk  (clk),
      .rst_n(mem_rst_n),
      .inc  (seq_inc),
      .cnt  (cnt),
      .full (full)
   );

   assign waddr = (mode_q == ACC_SEQ) ? cnt[AW-1:0] : loc_q;

   dmw_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .BLANK(BLANK)) u_store (
      .clk  (clk),
      .rst_n(mem_rst_n),
      .we   (commit),
      .waddr(waddr),
      .wdata(wdata),
      .raddr(scan_addr),
      .rdata(scan_data)
   );

   assign full_flag    = (mode_q == ACC_SEQ) & full & ~shutdown;
   assign write_active = act_q;

   // R7: the flag is quiet whenever random mode is in force
   p_full_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == ACC_RANDOM) |-> !full_flag);

   // R5: a sequential commit never happens on a full counter
   p_seq_accept_r5: assert property (@(posedge clk) disable iff (!mem_rst_n)
      seq_inc |-> !full);

endmodule

// File: tb/sim_dispmem_writer.sv
module sim_dispmem_writer;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, wr_n, cs_hi, cs_lo_n, mode_sel, ser_en, clr_n, shutdown;
   logic [2:0] loc_in, scan_addr;
   logic [5:0] wdata, scan_data;
   logic       full_flag, write_active;

   dispmem_writer u0 (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
      .mode_sel(mode_sel), .loc_in(loc_in), .ser_en(ser_en), .clr_n(clr_n),
      .wdata(wdata), .shutdown(shutdown), .scan_addr(scan_addr),
      .scan_data(scan_data), .full_flag(full_flag), .write_active(write_active)
   );

   int   n_chk = 0, n_fail = 0, cyc = 0;
   bit   done = 0;
   bit   m_valid = 0;
   logic m_mode;
   int   m_cnt;
   logic m_act;
   logic [5:0] m_mem [8];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   task automatic chk_mem(input string tag);
      for (int i = 0; i < 8; i++) begin
         scan_addr = 3'(i);
         #1;
         chk(scan_data == m_mem[i], tag, scan_data, m_mem[i]);
      end
   endtask

   // per-clock comparison against the model, away from both edges
   always @(posedge clk) begin
      cyc++;
      #3;
      if (m_valid && !done) begin
         logic expf;
         expf = m_mode && (m_cnt == 8) && !shutdown;
         chk(full_flag == expf, "R7 per-cycle full_flag", full_flag, expf);
         chk(write_active == m_act, "R9 per-cycle write_active", write_active, m_act);
      end
      if (cyc > 50000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
         finish_run();
      end
   end

   // how: 0 wr_n edges, 1 cs_hi edges, 2 cs_lo_n edges, 3 blocked by cs_hi
   task automatic do_write(input int how, input logic md, input logic [2:0] l,
                           input logic en, input logic [5:0] d,
                           input logic [2:0] l2, input logic [5:0] d2,
                           input string tag);
      bit acc;
      bit blocked;
      int a;
      blocked = (how == 3);
      @(negedge clk);
      m_valid = 0;
      mode_sel = md; loc_in = l; ser_en = en; wdata = d;
      case (how)
         1: begin cs_hi = 0; wr_n = 0; repeat (3) @(negedge clk); cs_hi = 1; end
         2: begin cs_lo_n = 1; wr_n = 0; repeat (3) @(negedge clk); cs_lo_n = 0; end
         3: begin cs_hi = 0; wr_n = 0; end
         default: wr_n = 0;
      endcase
      acc = blocked ? 1'b0 : (md ? (en && m_cnt < 8) : 1'b1);
      repeat (4) @(negedge clk);
      if (!blocked) m_mode = md;
      m_act = acc;
      m_valid = 1;
      chk(write_active == acc, {tag, " (R9 write_active held)"}, write_active, acc);
      loc_in = l2; wdata = d2;
      @(negedge clk);
      case (how)
         1: cs_hi = 0;
         2: cs_lo_n = 1;
         default: wr_n = 1;
      endcase
      m_valid = 0;
      repeat (4) @(negedge clk);
      if (acc) begin
         a = md ? m_cnt : int'(l);
         m_mem[a] = d2;
         if (md) m_cnt++;
      end
      m_act = 0;
      wr_n = 1; cs_hi = 1; cs_lo_n = 0;
      m_valid = 1;
      chk_mem(tag);
   endtask

   initial begin
      rst_n = 0; wr_n = 1; cs_hi = 1; cs_lo_n = 0; mode_sel = 0; loc_in = 0;
      ser_en = 0; clr_n = 1; wdata = 0; shutdown = 0; scan_addr = 0;
      m_mode = 0; m_cnt = 0; m_act = 0;
      for (int i = 0; i < 8; i++) m_mem[i] = 6'b100000;
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      m_valid = 1;

      chk(write_active == 0, "R10 write_active after reset", write_active, 0);
      chk(full_flag == 0, "R10 full_flag after reset", full_flag, 0);
      chk_mem("R10 cells blank after reset");

      do_write(0, 0, 3'd5, 0, 6'h11, 3'd5, 6'h11, "R2 R4 random write cell 5");
      do_write(0, 0, 3'd0, 0, 6'h2A, 3'd0, 6'h2A, "R4 random write cell 0");
      do_write(0, 0, 3'd2, 0, 6'h01, 3'd6, 6'h3C, "R3 R4 location and data moved mid-strobe");
      do_write(3, 0, 3'd4, 0, 6'h15, 3'd4, 6'h15, "R1 strobe blocked by cs_hi");
      do_write(1, 0, 3'd7, 0, 6'h33, 3'd7, 6'h33, "R1 edges formed by cs_hi");
      do_write(2, 0, 3'd1, 0, 6'h0F, 3'd1, 6'h0F, "R1 edges formed by cs_lo_n");

      do_write(0, 1, 3'd0, 0, 6'h3F, 3'd0, 6'h3F, "R5 sequential write with enable low");
      chk(full_flag == 0, "R7 not full before entries", full_flag, 0);
      for (int i = 0; i < 8; i++)
         do_write(0, 1, 3'd0, 1, 6'(32 + i), 3'd0, 6'(32 + i), "R6 sequential fill");
      chk(full_flag == 1, "R7 full after eight entries", full_flag, 1);
      do_write(0, 1, 3'd0, 1, 6'h01, 3'd0, 6'h01, "R5 write refused while full");

      @(negedge clk);
      shutdown = 1;
      #1;
      chk(full_flag == 0, "R7 shutdown hides full", full_flag, 0);
      @(negedge clk);
      shutdown = 0;
      #1;
      chk(full_flag == 1, "R7 full returns after shutdown", full_flag, 1);

      do_write(0, 0, 3'd3, 0, 6'h09, 3'd3, 6'h09, "R7 random write with full counter");
      chk(full_flag == 0, "R7 full low in random mode", full_flag, 0);

      @(negedge clk);
      clr_n = 0;
      #1;
      chk_mem("R8 clear ignored in random mode");
      clr_n = 1;

      do_write(0, 1, 3'd0, 0, 6'h00, 3'd0, 6'h00, "R2 return to sequential mode");
      chk(full_flag == 1, "R7 full visible again in sequential", full_flag, 1);

      @(negedge clk);
      clr_n = 0;
      #1;
      m_cnt = 0;
      for (int i = 0; i < 8; i++) m_mem[i] = 6'b100000;
      chk_mem("R8 clear blanks every cell");
      chk(full_flag == 0, "R8 clear drops full", full_flag, 0);
      @(negedge clk);
      clr_n = 1;
      repeat (4) @(negedge clk);

      do_write(0, 1, 3'd3, 1, 6'h2B, 3'd3, 6'h2B, "R6 first entry after clear at cell 0");

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule